// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block is a packed integer arithmetic unit. It treats each data word as four byte lanes or two halfword lanes. It takes one operation per cycle and registers the result, so the outputs appear on the clock edge after the request is accepted.

The unit performs lane-wise add and subtract in signed and unsigned forms. Each can wrap, saturate or halve. The halfword forms also come as exchange variants, which pair each half of `x` with the opposite half of `y`. A group of miscellaneous operations reads and writes the same flag state:
- sum of absolute byte differences, with an optional accumulator;
- byte-to-halfword extension, with an optional add;
- a per-byte select steered by four GE flags, which the wrapping forms leave behind;
- a per-halfword clamp to a programmable bit width, which raises a sticky Q flag.

The lane width is a parameter. A word is always four byte lanes, and a halfword is twice the byte width.

Top module: `simd_pack_alu`

## Requirements
- R1: While `rst` is high, and after it is released with no request, `out_valid`, `result`, `ge` and `q` are all zero.
- R2: An accepted request (`in_valid` = 1) gives `out_valid` = 1 exactly one cycle later. A cycle with `in_valid` = 0 gives `out_valid` = 0 and leaves `result`, `ge` and `q` unchanged.
- R3: Opcode fields are as follows. `op[6:5]` is the class: 0 = byte lanes, 1 = halfword lanes, 2 = miscellaneous, 3 = reserved. In the arithmetic classes, `op[2:1]` is the mode (0 and 3 = wrap, 1 = saturate, 2 = halve) and `op[0]` = 1 selects unsigned. In the wrap mode every lane returns the low bits of its own sum or difference, with no carry or borrow between lanes. In the byte class, `op[3]` = 1 selects subtract and `op[4]` is ignored.
- R4: The saturate mode clamps each lane to its range: signed bytes to −2^(B−1)..2^(B−1)−1, unsigned bytes to 0..2^B−1, and halfwords likewise with 2B bits.
- R5: The halve mode returns the exact sum or difference of each lane, shifted right by one. The shift rounds toward negative infinity, so it acts as an arithmetic shift for signed lanes and as a logical shift of the one-bit-wider result for unsigned lanes.
- R6: In the halfword class, `op[4:3]` selects the form:
  - 0: add;
  - 1: subtract;
  - 2: high = x.hi + y.lo and low = x.lo − y.hi;
  - 3: high = x.hi − y.lo and low = x.lo + y.hi.
- R7: A wrap-mode request updates `ge`: a byte lane i drives bit i, and halfword lane j drives bits 2j and 2j+1. For a signed lane the bit is 1 when the exact result is ≥ 0. For an unsigned add it is 1 on carry-out, and for an unsigned subtract it is 1 when no borrow occurs. Every other request leaves `ge` unchanged.
- R8: Misc function `op[3:0]` = 0 (select) takes byte i from `x` when `ge[i]` = 1 and from `y` otherwise.
- R9: Misc function 1 returns the sum of |x.byte − y.byte| over the four byte lanes. Function 2 adds `z` to that sum, wrapping to the word width.
- R10: Misc functions 3 and 4 return halfword j as byte 2j of `y`, sign-extended (3) or zero-extended (4). Functions 5 and 6 add that extended byte to halfword j of `x`, wrapping.
- R11: Misc function 7 clamps each signed halfword of `x` to a signed width of `y[S−1:0]`+1. Function 8 clamps it to an unsigned range of 0..2^`y[S−1:0]`−1, where S = log2(2B). `q` becomes 1 when either lane is altered and stays 1 until reset.
- R12: Class 3 and misc functions 9..15 return zero and leave `ge` and `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 7 | Operation code (class, form, mode, sign) |
| x | input | 4*BYTE_W | First operand |
| y | input | 4*BYTE_W | Second operand; low bits give the clamp width |
| z | input | 4*BYTE_W | Accumulator for the sum of absolute differences |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 4*BYTE_W | Registered result |
| ge | output | 4 | Per-byte comparison flags |
| q | output | 1 | Sticky clamp flag |

## Verification
The bench builds the unit with `BYTE_W` = 4, which makes a 16-bit word with 4-bit byte lanes and 8-bit halfword lanes. In that configuration, 256 vectors per opcode cover every operand pair of byte lane 0. The same vectors place each saturation boundary, the exchange crossover and the halving rounding in reach of every one of the 64 arithmetic opcodes. The clamp field shrinks to 3 bits, so every signed width (1..8) and unsigned width (0..7) is swept against the same 64 halfword values.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int OP_W  = 7;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    CL_BYTE = 2'd0,
    CL_HALF = 2'd1,
    CL_MISC = 2'd2,
    CL_RSVD = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    MD_WRAP  = 2'd0,
    MD_SAT   = 2'd1,
    MD_HALVE = 2'd2,
    MD_WRAP2 = 2'd3
  } mode_e;

  localparam logic [3:0] FN_SEL    = 4'd0;
  localparam logic [3:0] FN_SAD    = 4'd1;
  localparam logic [3:0] FN_SADA   = 4'd2;
  localparam logic [3:0] FN_XTB_S  = 4'd3;
  localparam logic [3:0] FN_XTB_U  = 4'd4;
  localparam logic [3:0] FN_XTAB_S = 4'd5;
  localparam logic [3:0] FN_XTAB_U = 4'd6;
  localparam logic [3:0] FN_CLMP_S = 4'd7;
  localparam logic [3:0] FN_CLMP_U = 4'd8;
endpackage

// File: rtl/simd_lane.sv
// One arithmetic lane: exact sum/difference in W+2 bits, then wrap, clamp or halve.
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         uns,
  input  logic [1:0]   mode,
  output logic [W-1:0] res,
  output logic         ge
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] SMAX = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] SMIN = {{(EW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [EW-1:0] UMAX = {2'b00, {W{1'b1}}};

  logic signed [EW-1:0] ae, be, s;

  always_comb begin
    ae = uns ? {2'b00, a} : {{2{a[W-1]}}, a};
    be = uns ? {2'b00, b} : {{2{b[W-1]}}, b};
    s  = sub ? (ae - be) : (ae + be);
  end

  always_comb begin
    case (mode)
      2'd1: begin
        if (uns) begin
          if (s < 0)         res = '0;
          else if (s > UMAX) res = '1;
          else               res = s[W-1:0];
        end else begin
          if (s > SMAX)      res = SMAX[W-1:0];
          else if (s < SMIN) res = SMIN[W-1:0];
          else               res = s[W-1:0];
        end
      end
      2'd2:    res = s[W:1];
      default: res = s[W-1:0];
    endcase
  end

  // unsigned add: carry out; everything else: exact result non-negative
  assign ge = (uns && !sub) ? s[W] : !s[EW-1];
endmodule

// File: rtl/simd_halfsat.sv
// Clamp one signed halfword to a programmable signed or unsigned width.
module simd_halfsat #(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  h,
  input  logic          uns,
  input  logic [SW-1:0] code,
  output logic [W-1:0]  res,
  output logic          clamp
);
  logic signed [W:0] v, pw, hi, lo;

  always_comb begin
    v  = {h[W-1], h};
    pw = (W+1)'(1) << code;
    hi = pw - 1;
    lo = uns ? '0 : -pw;
    clamp = 1'b1;
    if (v > hi)      res = hi[W-1:0];
    else if (v < lo) res = lo[W-1:0];
    else begin
      res   = h;
      clamp = 1'b0;
    end
  end
endmodule

// File: rtl/simd_pack_alu.sv
module simd_pack_alu
  import simd_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int WORD_W = 4 * BYTE_W,
  localparam int SAT_W  = $clog2(HALF_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op,
  input  logic [WORD_W-1:0] x,
  input  logic [WORD_W-1:0] y,
  input  logic [WORD_W-1:0] z,
  output logic              out_valid,
  output logic [WORD_W-1:0] result,
  output logic [3:0]        ge,
  output logic              q
);
  cls_e       cls;
  mode_e      md;
  logic [3:0] fn;
  logic       wrap;

  assign cls  = cls_e'(op[6:5]);
  assign md   = mode_e'(op[2:1]);
  assign fn   = op[3:0];
  assign wrap = (md == MD_WRAP) || (md == MD_WRAP2);

  // byte lanes (R3): op[4] plays no part here
  logic [BYTE_W-1:0] b_res [LANES];
  logic [LANES-1:0]  b_ge;

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .a(x[i*BYTE_W +: BYTE_W]), .b(y[i*BYTE_W +: BYTE_W]),
      .sub(op[3]), .uns(op[0]), .mode(op[2:1]),
      .res(b_res[i]), .ge(b_ge[i])
    );
  end

  // halfword lanes with exchange (R6) and the halfword clamps (R11)
  logic [HALF_W-1:0] h_res [2];
  logic [HALF_W-1:0] h_bop [2];
  logic [HALF_W-1:0] h_sat [2];
  logic [1:0]        h_ge, h_sub, h_clamp;

  for (genvar j = 0; j < 2; j++) begin : g_half
    assign h_bop[j] = op[4] ? y[(1-j)*HALF_W +: HALF_W] : y[j*HALF_W +: HALF_W];
    assign h_sub[j] = op[4] ? (op[3] ? (j == 1) : (j == 0)) : op[3];

    simd_lane #(.W(HALF_W)) u_lane (
      .a(x[j*HALF_W +: HALF_W]), .b(h_bop[j]),
      .sub(h_sub[j]), .uns(op[0]), .mode(op[2:1]),
      .res(h_res[j]), .ge(h_ge[j])
    );

    simd_halfsat #(.W(HALF_W), .SW(SAT_W)) u_clamp (
      .h(x[j*HALF_W +: HALF_W]), .uns(fn == FN_CLMP_U),
      .code(y[SAT_W-1:0]), .res(h_sat[j]), .clamp(h_clamp[j])
    );
  end

  // sum of absolute byte differences (R9)
  logic [WORD_W-1:0] sad_sum;
  always_comb begin
    logic [BYTE_W-1:0] xa, ya;
    sad_sum = (fn == FN_SADA) ? z : '0;
    for (int i = 0; i < LANES; i++) begin
      xa = x[i*BYTE_W +: BYTE_W];
      ya = y[i*BYTE_W +: BYTE_W];
      sad_sum = sad_sum + WORD_W'((xa > ya) ? (xa - ya) : (ya - xa));
    end
  end

  // byte-to-halfword extension with optional add (R10)
  logic [WORD_W-1:0] ext_res;
  always_comb begin
    logic [BYTE_W-1:0] yb;
    logic [HALF_W-1:0] ye;
    logic              zx;
    zx = (fn == FN_XTB_U) || (fn == FN_XTAB_U);
    for (int j = 0; j < 2; j++) begin
      yb = y[2*j*BYTE_W +: BYTE_W];
      ye = {{BYTE_W{yb[BYTE_W-1] & !zx}}, yb};
      ext_res[j*HALF_W +: HALF_W] = ye +
        (((fn == FN_XTAB_S) || (fn == FN_XTAB_U)) ? x[j*HALF_W +: HALF_W] : '0);
    end
  end

  // GE-steered select (R8)
  logic [WORD_W-1:0] sel_res;
  always_comb begin
    for (int i = 0; i < LANES; i++)
      sel_res[i*BYTE_W +: BYTE_W] = ge[i] ? x[i*BYTE_W +: BYTE_W] : y[i*BYTE_W +: BYTE_W];
  end

  logic [WORD_W-1:0] nxt_res;
  logic [3:0]        nxt_ge;
  logic              nxt_q;

  always_comb begin
    nxt_res = '0;
    nxt_ge  = ge;
    nxt_q   = q;
    case (cls)
      CL_BYTE: begin
        for (int i = 0; i < LANES; i++) nxt_res[i*BYTE_W +: BYTE_W] = b_res[i];
        if (wrap) nxt_ge = b_ge;
      end
      CL_HALF: begin
        nxt_res = {h_res[1], h_res[0]};
        if (wrap) nxt_ge = {h_ge[1], h_ge[1], h_ge[0], h_ge[0]};
      end
      CL_MISC: begin
        case (fn)
          FN_SEL:                         nxt_res = sel_res;
          FN_SAD, FN_SADA:                nxt_res = sad_sum;
          FN_XTB_S, FN_XTB_U,
          FN_XTAB_S, FN_XTAB_U:           nxt_res = ext_res;
          FN_CLMP_S, FN_CLMP_U: begin
            nxt_res = {h_sat[1], h_sat[0]};
            nxt_q   = q | (|h_clamp);
          end
          default:                        nxt_res = '0;
        endcase
      end
      default: nxt_res = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ge        <= '0;
      q         <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        ge     <= nxt_ge;
        q      <= nxt_q;
      end
    end
  end
endmodule

// File: rtl/simd_pack_alu_chk.sv
module simd_pack_alu_chk #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 4 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [6:0]        op,
  input logic [WORD_W-1:0] result,
  input logic              out_valid,
  input logic [3:0]        ge,
  input logic              q
);
  logic ge_writer, q_writer;
  assign ge_writer = in_valid && !op[6] && (op[2:1] != 2'd1) && (op[2:1] != 2'd2);
  assign q_writer  = in_valid && (op[6:5] == 2'd2) && ((op[3:0] == 4'd7) || (op[3:0] == 4'd8));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r2_result_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  a_r7_ge_untouched: assert property (@(posedge clk) disable iff (rst)
    !ge_writer |=> $stable(ge));
  a_r11_q_sticky: assert property (@(posedge clk) disable iff (rst)
    q |=> q);
  a_r11_q_only_clamp: assert property (@(posedge clk) disable iff (rst)
    !q_writer |=> $stable(q));
endmodule

bind simd_pack_alu simd_pack_alu_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .result(result),
  .out_valid(out_valid), .ge(ge), .q(q)
);

// File: tb/tb_simd_pack_alu.sv
module tb_simd_pack_alu;
  localparam int B = 4;
  localparam int H = 2 * B;
  localparam int W = 4 * B;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [6:0]   op = '0;
  logic [W-1:0] x = '0, y = '0, z = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic [3:0]   ge;
  logic         q;

  int checks = 0;
  int fails  = 0;
  logic [3:0] ge_m = '0;
  logic       q_m  = 1'b0;

  always #10 clk = ~clk;

  simd_pack_alu #(.BYTE_W(B)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .x(x), .y(y), .z(z),
    .out_valid(out_valid), .result(result), .ge(ge), .q(q)
  );

  function automatic int sx(int v, int w);
    return (v >= (1 << (w-1))) ? v - (1 << w) : v;
  endfunction

  function automatic int lane(int a0, int b0, int w, bit sb, bit un, int md, output bit g);
    int a, b, s, r;
    a = un ? a0 : sx(a0, w);
    b = un ? b0 : sx(b0, w);
    s = sb ? a - b : a + b;
    g = (un && !sb) ? (s >= (1 << w)) : (s >= 0);
    r = s;
    if (md == 1) begin
      if (un) r = (s < 0) ? 0 : ((s > (1 << w) - 1) ? (1 << w) - 1 : s);
      else    r = (s < -(1 << (w-1))) ? -(1 << (w-1)) : ((s > (1 << (w-1)) - 1) ? (1 << (w-1)) - 1 : s);
    end else if (md == 2) begin
      r = s >>> 1;
    end
    return r & ((1 << w) - 1);
  endfunction

  task automatic model(input logic [6:0] o, input int xi, input int yi, input int zi,
                       output int er, output logic [3:0] eg, output logic eq);
    int md, fnc, acc, v, hi, lo, code;
    bit g, un, wr;
    er = 0; eg = ge_m; eq = q_m;
    md = o[2:1]; un = o[0]; fnc = o[3:0];
    wr = (md == 0) || (md == 3);
    if (o[6:5] == 0) begin
      for (int i = 0; i < 4; i++) begin
        er |= lane((xi >> (B*i)) & 15, (yi >> (B*i)) & 15, B, o[3], un, md, g) << (B*i);
        if (wr) eg[i] = g;
      end
    end else if (o[6:5] == 1) begin
      for (int j = 0; j < 2; j++) begin
        int bs; bit sb;
        bs = o[4] ? ((yi >> (H*(1-j))) & 255) : ((yi >> (H*j)) & 255);
        sb = o[4] ? (o[3] ? (j == 1) : (j == 0)) : o[3];
        er |= lane((xi >> (H*j)) & 255, bs, H, sb, un, md, g) << (H*j);
        if (wr) begin eg[2*j] = g; eg[2*j+1] = g; end
      end
    end else if (o[6:5] == 2) begin
      case (fnc)
        0: for (int i = 0; i < 4; i++)
             er |= (ge_m[i] ? ((xi >> (B*i)) & 15) : ((yi >> (B*i)) & 15)) << (B*i);
        1, 2: begin
          acc = (fnc == 2) ? zi : 0;
          for (int i = 0; i < 4; i++) begin
            v = ((xi >> (B*i)) & 15) - ((yi >> (B*i)) & 15);
            acc += (v < 0) ? -v : v;
          end
          er = acc & 16'hFFFF;
        end
        3, 4, 5, 6: for (int j = 0; j < 2; j++) begin
          v = (yi >> (H*j)) & 15;
          if (fnc == 3 || fnc == 5) v = sx(v, B);
          if (fnc >= 5) v += (xi >> (H*j)) & 255;
          er |= (v & 255) << (H*j);
        end
        7, 8: begin
          code = yi & 7;
          for (int j = 0; j < 2; j++) begin
            v  = sx((xi >> (H*j)) & 255, H);
            hi = (1 << code) - 1;
            lo = (fnc == 8) ? 0 : -(1 << code);
            if (v > hi) begin v = hi; eq = 1'b1; end
            else if (v < lo) begin v = lo; eq = 1'b1; end
            er |= (v & 255) << (H*j);
          end
        end
        default: er = 0;
      endcase
    end
  endtask

  task automatic fail_line(string tag, string what, int act, int exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // one request; checks result/valid/q under tag, GE under gtag
  task automatic run(logic [6:0] o, logic [W-1:0] xi, logic [W-1:0] yi, logic [W-1:0] zi,
                     string tag, string gtag);
    int er; logic [3:0] eg; logic eq;
    model(o, xi, yi, zi, er, eg, eq);
    @(negedge clk);
    in_valid = 1'b1; op = o; x = xi; y = yi; z = zi;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if ({out_valid, result, q} !== {1'b1, er[W-1:0], eq})
      fail_line(tag, $sformatf("op %b x %h y %h vld/res/q", o, xi, yi),
                {out_valid, result, q}, {1'b1, er[W-1:0], eq});
    checks++;
    if (ge !== eg) fail_line(gtag, $sformatf("op %b ge", o), ge, eg);
    ge_m = eg; q_m = eq;
  endtask

  function automatic string mode_tag(int cl, int fm, int md);
    if (cl == 1 && fm >= 2) return "R6";
    if (md == 1) return "R4";
    if (md == 2) return "R5";
    return "R3";
  endfunction

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] xs, ys;
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, result, ge, q} !== '0) fail_line("R1", "reset outputs", {out_valid, result, ge, q}, 0);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if ({out_valid, result, ge, q} !== '0) fail_line("R1", "idle after reset", {out_valid, result, ge, q}, 0);

    // R2: result held and strobe low on an idle cycle
    run(7'b0000000, 16'h1234, 16'h1111, '0, "R2", "R7");
    x = 16'hFFFF; y = 16'hFFFF; op = 7'b0000010;
    @(negedge clk);
    checks++;
    if ({out_valid, result, ge} !== {1'b0, 16'h2345, ge_m})
      fail_line("R2", "idle hold", {out_valid, result, ge}, {1'b0, 16'h2345, ge_m});

    // arithmetic classes: every class/form/mode/sign with byte lane 0 swept fully
    for (int cl = 0; cl < 2; cl++)
      for (int fm = 0; fm < 4; fm++)
        for (int md = 0; md < 4; md++)
          for (int un = 0; un < 2; un++)
            for (int k = 0; k < 256; k++) begin
              xs = {k[7:0], k[3:0] ^ 4'hA, k[7:4]};
              ys = {8'(k * 7 + 3), k[7:4] ^ 4'h9, k[3:0]};
              run({cl[1:0], fm[1:0], md[1:0], un[0]}, xs, ys, '0,
                  mode_tag(cl, fm, md), "R7");
            end

    // R8: select after GE set by a wrapping op
    for (int k = 0; k < 256; k++) begin
      run(7'b0001000, {k[3:0], k[7:4], 4'(k*3), 4'(k*5)}, {4'(k), 4'(k*7), 4'(k+2), 4'(k*11)}, '0, "R3", "R7");
      run(7'b1000000, {k[7:0], 8'(k*13)}, {8'(k*29), ~k[7:0]}, '0, "R8", "R7");
    end

    // R9: absolute difference sums, plain and accumulating
    for (int k = 0; k < 256; k++) begin
      run(7'b1000001, {k[7:0], k[3:0], k[7:4]}, {~k[7:0], 8'(k * 9)}, 16'(k * 251), "R9", "R7");
      run(7'b1000010, {k[7:0], k[3:0], k[7:4]}, {~k[7:0], 8'(k * 9)}, 16'(k * 251 + 16'hFFC0), "R9", "R7");
    end

    // R10: extension with and without add
    for (int f = 3; f <= 6; f++)
      for (int k = 0; k < 256; k++)
        run({3'b100, f[3:0]}, {8'(k * 37), k[7:0]}, {k[3:0], k[7:4], ~k[7:4], k[3:0]}, '0, "R10", "R7");

    // R11: halfword clamp over every width code
    for (int f = 7; f <= 8; f++)
      for (int c = 0; c < 8; c++)
        for (int k = 0; k < 64; k++)
          run({3'b100, f[3:0]}, {8'(k * 4 + 1), 8'(k * 4 + 130)}, {13'(k), c[2:0]}, '0, "R11", "R7");
    run(7'b0000000, 16'h0101, 16'h0101, '0, "R11", "R7");
    checks++;
    if (q !== 1'b1) fail_line("R11", "q sticky", q, 1);

    // R12: reserved codes
    for (int f = 9; f < 16; f++)
      run({3'b100, f[3:0]}, 16'hBEEF, 16'h1357, 16'h2468, "R12", "R12");
    for (int k = 0; k < 16; k++)
      run({2'b11, k[4:0]}, 16'h7777, 16'h8888, '0, "R12", "R12");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule